// File: doc/BRIEF.md
# Floating-Point Exception Cause and Result Fixup

This block is the exception-control slice of a floating-point unit. The arithmetic datapath hands it a finished raw result, the raw IEEE exception indications from that operation, and the source operands. In one clock edge the block classifies the operands and the result, works out which cause bits the operation raises, and updates the sticky flags. It then decides whether the operation traps. An operation that does not trap gets its written-back value, with quiet-NaN results replaced by a fixed pattern and, when flush mode allows it, subnormal results replaced by a zero or a minimum normal chosen by the rounding mode.

The block owns the 32-bit control/status word. Software reads and writes it through a simple write-enable port and a registered read port, and the 2-bit rounding mode is also output on its own for the datapath. A trap drops the write-back: `wb_valid` stays low, so the destination register is left untouched. A control-word write whose cause bits meet their enables raises the trap as well.

Top module: `fpx_unit`

## Requirements
- R1: After a synchronous active-high reset the control word reads 0, `rnd_mode` is 0, and `trap` and `wb_valid` are low.
- R2: Control-word layout: rounding mode in bits 1:0 (0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf), flags in 6:2, enables in 11:7, causes in 17:12, and flush enable in bit 24. All other bits read 0. A write takes effect at the next edge, and `rnd_mode` mirrors bits 1:0. Exception bit order, used by flags, enables, causes and `raw_exc`: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid, and cause-only bit 5 unimplemented.
- R3: An operation traps exactly when its cause bits ANDed with {1, enables} are nonzero, so the unimplemented cause always traps. A trap keeps `wb_valid` low.
- R4: Each of the five IEEE cause bits an operation raises sets its flag only when its enable is clear. Flags are never cleared except by a control-word write.
- R5: Every accepted operation replaces the whole cause field. Causes from an earlier operation do not carry over.
- R6: A raw underflow, when flush is off or the underflow or inexact enable is set, raises only the unimplemented cause and the other raw indications are dropped. Otherwise each raw indication sets its own cause.
- R7: For arithmetic, an operand that is a signalling NaN or a subnormal raises only unimplemented. An operand that is a quiet NaN (exponent all ones, top fraction bit 1) raises invalid, and if invalid is enabled nothing more is evaluated. Operand B is examined only when `op_use_b` is high.
- R8: A non-trapping arithmetic NaN result is written back as 0x7FBFFFFF (single) or 0x7FF7FFFFFFFFFFFF (double).
- R9: A subnormal arithmetic result raises unimplemented when flush is off or the underflow or inexact enable is set. Otherwise it raises underflow and inexact and is replaced as follows: modes 0 and 1 give a zero of the same sign, mode 2 gives -0 if negative and +min-normal if positive, and mode 3 gives -min-normal if negative and +0 if positive.
- R10: For a float-to-integer conversion (`op_cvt`), an operand A that is NaN, infinite or subnormal, or whose magnitude is at least 2^31 (`op_long` low) or 2^53 (`op_long` high), raises unimplemented.
- R11: For a conversion, raw invalid raises unimplemented. Otherwise the raw indications apply as in R6, and the 64-bit result is written back unchanged.
- R12: A control-word write traps when the written cause ANDed with {1, written enables} is nonzero. An operation presented in the same cycle as a write is dropped: no write-back and no state change from it.
- R13: A single-precision arithmetic write-back has bits 63:32 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control-word write strobe |
| csr_wdata | input | 32 | Control-word write data |
| csr_rdata | output | 32 | Control-word read data |
| rnd_mode | output | 2 | Current rounding mode |
| op_valid | input | 1 | An operation completes this cycle |
| op_cvt | input | 1 | Operation is a float-to-integer conversion |
| op_dbl | input | 1 | Source format is double precision |
| op_long | input | 1 | Conversion target is 64-bit integer |
| op_use_b | input | 1 | Operand B takes part in the operation |
| opnd_a | input | 64 | Operand A (single in bits 31:0) |
| opnd_b | input | 64 | Operand B (single in bits 31:0) |
| raw_exc | input | 5 | Raw IEEE exception indications |
| op_result | input | 64 | Raw result from the datapath |
| wb_valid | output | 1 | Write back `wb_data` to the destination |
| wb_data | output | 64 | Fixed-up write-back value |
| trap | output | 1 | Floating-point exception trap |

## Verification
All 32 raw-indication patterns are swept against several enable sets, with flush on and off, on an operation with clean operands and a normal result. This separates underflow promotion from plain cause setting, and enabled causes, which trap and leave flags alone, from disabled ones, which set flags. A second sweep runs subnormal results of both signs in both precisions through all four rounding modes, which tells the four flush substitutions apart. Directed cases cover signalling, quiet and subnormal operands, including an ignored operand B. They also put conversion operands on each side of the 2^31 and 2^53 limits, and cover NaN results, sticky flags across a clean operation, and a write that collides with an operation.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W  = 5;
  localparam int CAUSE_W = 6;
  localparam int CSR_W   = 32;
  localparam int DATA_W  = 64;

  // exception bit order shared by flags, enables, causes and raw input
  localparam int EX_INEX  = 0;
  localparam int EX_UNDF  = 1;
  localparam int EX_OVFL  = 2;
  localparam int EX_DIVZ  = 3;
  localparam int EX_INVL  = 4;
  localparam int EX_UNIMP = 5;

  // control word field positions
  localparam int RM_LO    = 0;
  localparam int FLAG_LO  = 2;
  localparam int EN_LO    = FLAG_LO + FLAG_W;
  localparam int CAUSE_LO = EN_LO + FLAG_W;
  localparam int FLUSH_B  = 24;

  localparam int BIAS_S = 127;
  localparam int BIAS_D = 1023;

  localparam logic [31:0] NAN_FIX_S = 32'h7FBF_FFFF;
  localparam logic [63:0] NAN_FIX_D = 64'h7FF7_FFFF_FFFF_FFFF;
  localparam logic [31:0] MINN_S    = 32'h0080_0000;
  localparam logic [63:0] MINN_D    = 64'h0010_0000_0000_0000;

  typedef enum logic [1:0] {FIX_NONE, FIX_NAN, FIX_SUB} fix_e;

  // raw indications mapped to causes, with underflow promotion
  function automatic logic [CAUSE_W-1:0] map_raw(input logic [FLAG_W-1:0] raw,
                                                 input logic promote);
    logic [CAUSE_W-1:0] c;
    c = '0;
    if (raw[EX_UNDF] && promote) c[EX_UNIMP] = 1'b1;
    else                         c[FLAG_W-1:0] = raw;
    return c;
  endfunction
endpackage

// File: rtl/fpx_opclass.sv
module fpx_opclass
  import fpx_pkg::*;
#(
  parameter int WORD_BITS = 31,
  parameter int LONG_BITS = 53
) (
  input  logic [DATA_W-1:0] val,
  input  logic              dbl,
  input  logic              lng,
  input  logic              cvt,
  output logic              bad,
  output logic              qnan
);
  localparam int TW = 12;

  logic [10:0]   expo;
  logic          all1, frac_nz, frac_msb;
  logic [TW-1:0] thr;
  logic          is_nan, is_snan, is_sub, is_inf, is_big;
  logic          unused_sign;

  assign unused_sign = val[63] ^ val[31];

  always_comb begin
    if (dbl) begin
      expo     = val[62:52];
      all1     = &val[62:52];
      frac_nz  = |val[51:0];
      frac_msb = val[51];
      thr      = TW'(BIAS_D + (lng ? LONG_BITS : WORD_BITS));
    end else begin
      expo     = {3'b000, val[30:23]};
      all1     = &val[30:23];
      frac_nz  = |val[22:0];
      frac_msb = val[22];
      thr      = TW'(BIAS_S + (lng ? LONG_BITS : WORD_BITS));
    end
  end

  always_comb begin
    is_nan  = all1 & frac_nz;
    is_snan = is_nan & ~frac_msb;
    is_sub  = (expo == '0) & frac_nz;
    is_inf  = all1 & ~frac_nz;
    is_big  = ({1'b0, expo} >= thr);
    if (cvt) begin
      bad  = is_nan | is_inf | is_sub | is_big;
      qnan = 1'b0;
    end else begin
      bad  = is_snan | is_sub;
      qnan = all1 & frac_msb;
    end
  end
endmodule

// File: rtl/fpx_resfix.sv
module fpx_resfix
  import fpx_pkg::*;
(
  input  logic [DATA_W-1:0] res,
  input  logic              dbl,
  input  logic              cvt,
  input  logic [1:0]        rm,
  input  fix_e              sel,
  output logic              res_nan,
  output logic              res_sub,
  output logic [DATA_W-1:0] wb_val
);
  logic all1, frac_nz, exp0, sgn;

  always_comb begin
    if (dbl) begin
      all1    = &res[62:52];
      exp0    = ~|res[62:52];
      frac_nz = |res[51:0];
      sgn     = res[63];
    end else begin
      all1    = &res[30:23];
      exp0    = ~|res[30:23];
      frac_nz = |res[22:0];
      sgn     = res[31];
    end
    res_nan = all1 & frac_nz;
    res_sub = exp0 & frac_nz;
  end

  function automatic logic [DATA_W-1:0] szero(input logic d, input logic s);
    return d ? {s, 63'd0} : {32'd0, s, 31'd0};
  endfunction

  function automatic logic [DATA_W-1:0] sminn(input logic d, input logic s);
    return d ? (MINN_D | {s, 63'd0}) : {32'd0, MINN_S | {s, 31'd0}};
  endfunction

  always_comb begin
    unique case (sel)
      FIX_NAN: wb_val = dbl ? NAN_FIX_D : {32'd0, NAN_FIX_S};
      FIX_SUB: begin
        unique case (rm)
          2'd2:    wb_val = sgn ? szero(dbl, 1'b1) : sminn(dbl, 1'b0);
          2'd3:    wb_val = sgn ? sminn(dbl, 1'b1) : szero(dbl, 1'b0);
          default: wb_val = szero(dbl, sgn);
        endcase
      end
      default: wb_val = (cvt || dbl) ? res : {32'd0, res[31:0]};
    endcase
  end
endmodule

// File: rtl/fpx_cause.sv
module fpx_cause
  import fpx_pkg::*;
(
  input  logic               is_cvt,
  input  logic               opnd_bad,
  input  logic               opnd_qnan,
  input  logic [FLAG_W-1:0]  raw,
  input  logic [FLAG_W-1:0]  en,
  input  logic               flush,
  input  logic               res_nan,
  input  logic               res_sub,
  output logic [CAUSE_W-1:0] cause,
  output logic               trap,
  output fix_e               sel
);
  logic promote;

  function automatic logic hits(input logic [CAUSE_W-1:0] c,
                                input logic [FLAG_W-1:0] e);
    return |(c & {1'b1, e});
  endfunction

  always_comb begin
    promote = ~flush | en[EX_UNDF] | en[EX_INEX];
    cause   = '0;
    sel     = FIX_NONE;
    if (is_cvt) begin
      if (opnd_bad || raw[EX_INVL]) cause[EX_UNIMP] = 1'b1;
      else                          cause = map_raw(raw, promote);
    end else if (opnd_bad) begin
      cause[EX_UNIMP] = 1'b1;
    end else begin
      cause[EX_INVL] = opnd_qnan;
      if (!(opnd_qnan && en[EX_INVL])) begin
        cause = cause | map_raw(raw, promote);
        if (!hits(cause, en)) begin
          if (res_nan) begin
            sel = FIX_NAN;
          end else if (res_sub) begin
            if (promote) begin
              cause[EX_UNIMP] = 1'b1;
            end else begin
              cause[EX_UNDF] = 1'b1;
              cause[EX_INEX] = 1'b1;
              sel            = FIX_SUB;
            end
          end
        end
      end
    end
    trap = hits(cause, en);
  end
endmodule

// File: rtl/fpx_unit.sv
module fpx_unit
  import fpx_pkg::*;
#(
  parameter int WORD_INT_BITS = 31,
  parameter int LONG_INT_BITS = 53,
  parameter int N_OPND        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic [1:0]        rnd_mode,
  input  logic              op_valid,
  input  logic              op_cvt,
  input  logic              op_dbl,
  input  logic              op_long,
  input  logic              op_use_b,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [FLAG_W-1:0] raw_exc,
  input  logic [DATA_W-1:0] op_result,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data,
  output logic              trap
);
  logic [1:0]         rm_q;
  logic [FLAG_W-1:0]  flag_q, en_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               flush_q;
  logic               trap_q, wbv_q;
  logic [DATA_W-1:0]  wbd_q;

  logic [DATA_W-1:0]  opnd [N_OPND];
  logic [N_OPND-1:0]  o_bad, o_qnan, o_used;
  logic               any_bad, any_qnan;
  logic               res_nan, res_sub, trap_nx;
  logic [CAUSE_W-1:0] cause_nx;
  fix_e               sel;
  logic [DATA_W-1:0]  wb_val;
  logic [FLAG_W-1:0]  w_en;
  logic [CAUSE_W-1:0] w_cause;
  logic               unused_wbits;

  assign opnd[0]   = opnd_a;
  assign opnd[1]   = opnd_b;
  assign o_used[0] = 1'b1;
  assign o_used[1] = op_use_b & ~op_cvt;

  generate
    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
      fpx_opclass #(.WORD_BITS(WORD_INT_BITS), .LONG_BITS(LONG_INT_BITS)) u_cls (
        .val (opnd[i]),
        .dbl (op_dbl),
        .lng (op_long),
        .cvt (op_cvt),
        .bad (o_bad[i]),
        .qnan(o_qnan[i])
      );
    end
  endgenerate

  assign any_bad  = |(o_bad & o_used);
  assign any_qnan = |(o_qnan & o_used);

  fpx_resfix u_fix (
    .res    (op_result),
    .dbl    (op_dbl),
    .cvt    (op_cvt),
    .rm     (rm_q),
    .sel    (sel),
    .res_nan(res_nan),
    .res_sub(res_sub),
    .wb_val (wb_val)
  );

  fpx_cause u_cause (
    .is_cvt   (op_cvt),
    .opnd_bad (any_bad),
    .opnd_qnan(any_qnan),
    .raw      (raw_exc),
    .en       (en_q),
    .flush    (flush_q),
    .res_nan  (res_nan),
    .res_sub  (res_sub),
    .cause    (cause_nx),
    .trap     (trap_nx),
    .sel      (sel)
  );

  assign w_en         = csr_wdata[EN_LO +: FLAG_W];
  assign w_cause      = csr_wdata[CAUSE_LO +: CAUSE_W];
  assign unused_wbits = ^{csr_wdata[CSR_W-1:FLUSH_B+1], csr_wdata[FLUSH_B-1:CAUSE_LO+CAUSE_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rm_q    <= '0;
      flag_q  <= '0;
      en_q    <= '0;
      cause_q <= '0;
      flush_q <= 1'b0;
      trap_q  <= 1'b0;
      wbv_q   <= 1'b0;
      wbd_q   <= '0;
    end else begin
      trap_q <= 1'b0;
      wbv_q  <= 1'b0;
      if (csr_we) begin
        rm_q    <= csr_wdata[RM_LO +: 2];
        flag_q  <= csr_wdata[FLAG_LO +: FLAG_W];
        en_q    <= w_en;
        cause_q <= w_cause;
        flush_q <= csr_wdata[FLUSH_B];
        trap_q  <= |(w_cause & {1'b1, w_en});
      end else if (op_valid) begin
        cause_q <= cause_nx;
        flag_q  <= flag_q | (cause_nx[FLAG_W-1:0] & ~en_q);
        trap_q  <= trap_nx;
        wbv_q   <= ~trap_nx;
        if (!trap_nx) wbd_q <= wb_val;
      end
    end
  end

  always_comb begin
    csr_rdata                      = '0;
    csr_rdata[RM_LO +: 2]          = rm_q;
    csr_rdata[FLAG_LO +: FLAG_W]   = flag_q;
    csr_rdata[EN_LO +: FLAG_W]     = en_q;
    csr_rdata[CAUSE_LO +: CAUSE_W] = cause_q;
    csr_rdata[FLUSH_B]             = flush_q;
  end

  assign rnd_mode = rm_q;
  assign wb_valid = wbv_q;
  assign wb_data  = wbd_q;
  assign trap     = trap_q;

  // R3
  trap_blocks_wb_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> !wbv_q);

  // R3
  unimp_never_writes_chk: assert property (@(posedge clk) disable iff (rst)
    wbv_q |-> !cause_q[EX_UNIMP]);

  // R4
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(csr_we) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R4
  enabled_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(csr_we) |-> (((flag_q & ~$past(flag_q)) & en_q) == '0));

  // R2
  rm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(csr_we) |-> $stable(rm_q));

  // R12
  write_drops_op_chk: assert property (@(posedge clk) disable iff (rst)
    $past(csr_we) |-> !wbv_q);
endmodule

// File: tb/tb_fpx_unit.sv
module tb_fpx_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [1:0]  rnd_mode;
  logic        op_valid = 1'b0, op_cvt = 1'b0, op_dbl = 1'b0, op_long = 1'b0, op_use_b = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0, op_result = '0;
  logic [4:0]  raw_exc = '0;
  logic        wb_valid, trap;
  logic [63:0] wb_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  fpx_unit dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rnd_mode(rnd_mode), .op_valid(op_valid), .op_cvt(op_cvt), .op_dbl(op_dbl),
    .op_long(op_long), .op_use_b(op_use_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .raw_exc(raw_exc), .op_result(op_result), .wb_valid(wb_valid), .wb_data(wb_data),
    .trap(trap)
  );

  function automatic logic [31:0] pack(input logic [1:0] rm, input logic [4:0] fl,
                                       input logic [4:0] en, input logic [5:0] ca,
                                       input logic fs);
    return {7'd0, fs, 6'd0, ca, en, fl, rm};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [31:0] v);
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic do_op(input logic cvt, input logic dbl, input logic lng, input logic ub,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [4:0] rx, input logic [63:0] r);
    @(negedge clk);
    op_valid = 1'b1; op_cvt = cvt; op_dbl = dbl; op_long = lng; op_use_b = ub;
    opnd_a = a; opnd_b = b; raw_exc = rx; op_result = r;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  localparam logic [63:0] ONE_S = 64'h3F80_0000;
  localparam logic [63:0] TWO_S = 64'h4000_0000;
  localparam logic [31:0] E_ONLY = 32'h0002_0000;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] ens [5];
    ens[0] = 5'h00; ens[1] = 5'h1F; ens[2] = 5'h01; ens[3] = 5'h02; ens[4] = 5'h15;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 csr", {32'd0, csr_rdata}, 64'd0);
    chk("R1 rm", {62'd0, rnd_mode}, 64'd0);
    chk("R1 trap", {63'd0, trap}, 64'd0);
    chk("R1 wbv", {63'd0, wb_valid}, 64'd0);

    // R2 layout, R12 write trap
    wr_csr(32'hFFFF_FFFF);
    chk("R2 csr all ones", {32'd0, csr_rdata}, 64'h0103_FFFF);
    chk("R2 rm out", {62'd0, rnd_mode}, 64'd3);
    chk("R12 write trap", {63'd0, trap}, 64'd1);
    wr_csr(pack(2'd0, 5'd0, 5'h10, 6'h10, 1'b0));
    chk("R12 enabled cause write traps", {63'd0, trap}, 64'd1);
    wr_csr(pack(2'd1, 5'd0, 5'h00, 6'h10, 1'b0));
    chk("R12 disabled cause write", {63'd0, trap}, 64'd0);
    chk("R2 rm 1", {62'd0, rnd_mode}, 64'd1);

    // R12 collision: write wins, op dropped
    @(negedge clk);
    csr_we = 1'b1; csr_wdata = pack(2'd2, 5'd0, 5'd0, 6'd0, 1'b0);
    op_valid = 1'b1; op_cvt = 0; op_dbl = 0; op_use_b = 1; opnd_a = ONE_S; opnd_b = ONE_S;
    raw_exc = 5'h01; op_result = TWO_S;
    @(negedge clk);
    csr_we = 1'b0; op_valid = 1'b0;
    chk("R12 collision wbv", {63'd0, wb_valid}, 64'd0);
    chk("R12 collision csr", {32'd0, csr_rdata}, {32'd0, pack(2'd2, 5'd0, 5'd0, 6'd0, 1'b0)});

    // R6 / R3 / R4 sweep
    for (int fs = 0; fs < 2; fs++) begin
      for (int k = 0; k < 5; k++) begin
        for (int rx = 0; rx < 32; rx++) begin
          logic [4:0] en, fl;
          logic [5:0] ca;
          logic prom, tr;
          en = ens[k];
          wr_csr(pack(2'd0, 5'd0, en, 6'd0, fs[0]));
          do_op(0, 0, 0, 1, ONE_S, ONE_S, rx[4:0], TWO_S);
          prom = (fs == 0) || en[1] || en[0];
          ca = (rx[1] && prom) ? 6'h20 : {1'b0, rx[4:0]};
          tr = ca[5] || ((ca[4:0] & en) != 0);
          fl = ca[4:0] & ~en;
          chk("R6 sweep csr", {32'd0, csr_rdata}, {32'd0, pack(2'd0, fl, en, ca, fs[0])});
          chk("R3 sweep trap", {63'd0, trap}, {63'd0, tr});
          chk("R3 sweep wbv", {63'd0, wb_valid}, {63'd0, !tr});
          if (!tr) chk("R13 sweep data", wb_data, TWO_S);
        end
      end
    end

    // R9 subnormal flush sweep
    for (int d = 0; d < 2; d++) begin
      for (int rm = 0; rm < 4; rm++) begin
        for (int s = 0; s < 2; s++) begin
          logic [63:0] r, z, mn, ex;
          r  = d ? {s[0], 62'd0, 1'b1} : {32'd0, s[0], 30'd0, 1'b1};
          z  = d ? {s[0], 63'd0} : {32'd0, s[0], 31'd0};
          mn = d ? ({s[0], 63'd0} | 64'h0010_0000_0000_0000)
                 : {32'd0, {s[0], 31'd0} | 32'h0080_0000};
          if (rm < 2)       ex = z;
          else if (rm == 2) ex = s ? z : mn;
          else              ex = s ? mn : z;
          wr_csr(pack(rm[1:0], 5'd0, 5'd0, 6'd0, 1'b1));
          do_op(0, d[0], 0, 0, d ? 64'h3FF0_0000_0000_0000 : ONE_S, 64'd0, 5'd0, r);
          chk("R9 flush data", wb_data, ex);
          chk("R9 flush csr", {32'd0, csr_rdata},
              {32'd0, pack(rm[1:0], 5'h03, 5'd0, 6'h03, 1'b1)});
        end
      end
    end
    wr_csr(32'd0);
    do_op(0, 0, 0, 0, ONE_S, 0, 5'd0, 64'h0000_0001);
    chk("R9 no flush trap", {63'd0, trap}, 64'd1);
    chk("R9 no flush csr", {32'd0, csr_rdata}, {32'd0, E_ONLY});
    wr_csr(pack(2'd0, 5'd0, 5'h01, 6'd0, 1'b1));
    do_op(0, 0, 0, 0, ONE_S, 0, 5'd0, 64'h0000_0001);
    chk("R9 inexact enable promotes", {32'd0, csr_rdata},
        {32'd0, pack(2'd0, 5'd0, 5'h01, 6'h20, 1'b1)});

    // R8 / R13
    wr_csr(32'd0);
    do_op(0, 0, 0, 0, ONE_S, 0, 5'd0, 64'h7FC0_0000);
    chk("R8 single nan", wb_data, 64'h7FBF_FFFF);
    do_op(0, 1, 0, 0, 64'h3FF0_0000_0000_0000, 0, 5'd0, 64'hFFF8_0000_0000_0000);
    chk("R8 double nan", wb_data, 64'h7FF7_FFFF_FFFF_FFFF);
    do_op(0, 0, 0, 0, ONE_S, 0, 5'd0, 64'hDEAD_BEEF_3F80_0000);
    chk("R13 upper zero", wb_data, 64'h0000_0000_3F80_0000);

    // R7 operands, R5 cause clear
    do_op(0, 0, 0, 1, 64'h7F80_0001, ONE_S, 5'd0, TWO_S);
    chk("R7 snan trap", {63'd0, trap}, 64'd1);
    chk("R7 snan csr", {32'd0, csr_rdata}, {32'd0, E_ONLY});
    do_op(0, 0, 0, 1, ONE_S, 64'h0000_0001, 5'd0, TWO_S);
    chk("R7 sub b trap", {63'd0, trap}, 64'd1);
    do_op(0, 0, 0, 0, ONE_S, 64'h0000_0001, 5'd0, TWO_S);
    chk("R7 b ignored wbv", {63'd0, wb_valid}, 64'd1);
    chk("R5 cause cleared", {32'd0, csr_rdata}, 64'd0);
    do_op(0, 0, 0, 0, 64'h7FC0_0000, 0, 5'd0, 64'h7FC0_0000);
    chk("R7 qnan csr", {32'd0, csr_rdata}, 64'h0001_0040);
    chk("R7 qnan data", wb_data, 64'h7FBF_FFFF);
    wr_csr(pack(2'd0, 5'd0, 5'h10, 6'd0, 1'b0));
    do_op(0, 0, 0, 1, ONE_S, 64'h7FC0_0000, 5'h01, TWO_S);
    chk("R7 qnan enabled trap", {63'd0, trap}, 64'd1);
    chk("R4 enabled no flag", {32'd0, csr_rdata}, 64'h0001_0800);

    // R4 sticky, R5
    wr_csr(32'd0);
    do_op(0, 0, 0, 0, ONE_S, 0, 5'h01, TWO_S);
    chk("R4 flag set", {32'd0, csr_rdata}, 64'h0000_1004);
    do_op(0, 0, 0, 0, ONE_S, 0, 5'h00, TWO_S);
    chk("R4 flag sticky R5 clear", {32'd0, csr_rdata}, 64'h0000_0004);

    // R10 / R11 conversions
    wr_csr(32'd0);
    do_op(1, 0, 0, 0, 64'h4F00_0000, 0, 5'd0, 0);
    chk("R10 word 2^31", {63'd0, trap}, 64'd1);
    chk("R10 word csr", {32'd0, csr_rdata}, {32'd0, E_ONLY});
    do_op(1, 0, 0, 0, 64'hCF00_0000, 0, 5'd0, 0);
    chk("R10 word -2^31", {63'd0, trap}, 64'd1);
    do_op(1, 0, 0, 0, 64'h4EFF_FFFF, 0, 5'd0, 64'hFFFF_FFFF_7FFF_FF80);
    chk("R10 word below", {63'd0, wb_valid}, 64'd1);
    chk("R11 passthrough", wb_data, 64'hFFFF_FFFF_7FFF_FF80);
    do_op(1, 0, 1, 0, 64'h5A00_0000, 0, 5'd0, 0);
    chk("R10 single long 2^53", {63'd0, trap}, 64'd1);
    do_op(1, 1, 1, 0, 64'h4340_0000_0000_0000, 0, 5'd0, 0);
    chk("R10 double long 2^53", {63'd0, trap}, 64'd1);
    do_op(1, 1, 1, 0, 64'h433F_FFFF_FFFF_FFFF, 0, 5'd0, 64'h001F_FFFF_FFFF_FFFF);
    chk("R10 double long below", wb_data, 64'h001F_FFFF_FFFF_FFFF);
    do_op(1, 0, 0, 0, 64'h7F80_0000, 0, 5'd0, 0);
    chk("R10 inf", {63'd0, trap}, 64'd1);
    do_op(1, 0, 0, 0, ONE_S, 0, 5'h10, 0);
    chk("R11 invalid promoted", {32'd0, csr_rdata}, {32'd0, E_ONLY});
    chk("R11 invalid trap", {63'd0, trap}, 64'd1);
    do_op(1, 0, 0, 0, 64'h3FC0_0000, 0, 5'h01, 64'd2);
    chk("R11 inexact csr", {32'd0, csr_rdata}, 64'h0000_1004);
    chk("R11 inexact data", wb_data, 64'd2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule